// File: doc/BRIEF.md
# Two-Port Mailbox Register Bank

The block is a set of eight 32-bit mailbox registers that pass short messages between a host-side target port and a local-side port running on one clock. Four mailboxes carry data from host to local (host-to-local, boxes H0..H3) and four carry data from local to host (boxes L0..L3). Each port sees its own sending mailboxes as "outgoing" and the other direction as "incoming". Every byte of every mailbox has a full flag. A write sets it, and a read by the receiving port clears it.

Each port has an interrupt with two causes that are enabled separately. The "incoming full" cause fires when the peer writes a chosen byte of a chosen incoming mailbox. The "outgoing empty" cause fires when the peer reads a chosen byte of a chosen outgoing mailbox that was full. Pending causes are sticky and are cleared by writing 1. The host interrupt is registered. The local interrupt drops in the same cycle as the clearing write. The local port can be run as a 16-bit bus. The host port flags burst attempts so that the bus wrapper can disconnect.

Top module: `mbox_bank`

## Requirements
- R1: During and after synchronous reset all full flags are 0, every mailbox and configuration field is 0, both interrupts and `h_disc` are low, and read data is 0.
- R2: Per-port word map on `addr`: words 0..3 are the port's outgoing mailboxes, words 4..7 its incoming mailboxes, word 8 is interrupt control and word 9 is status. Status is {incoming flags[15:0], outgoing flags[15:0]}, with the flag of box k, byte b at bit 4k+b of each half. A write to outgoing box k sets the flags of its enabled bytes. A read of incoming box k returns the data in the cycle after the access and clears the flags of its enabled bytes.
- R3: A write to an outgoing mailbox that is already full replaces only the enabled bytes. The flags stay set and nothing signals an error.
- R4: A read of an empty incoming mailbox returns the last stored value and leaves the flags clear.
- R5: `h_disc` is high in the cycle after a host access made with `h_burst` high, and low after any other cycle.
- R6: Control word layout: [1:0] incoming byte, [3:2] incoming box, [4] incoming-full enable, [9:8] outgoing byte, [11:10] outgoing box, [12] outgoing-empty enable, [16] incoming-full pending, [17] outgoing-empty pending. Byte enable 0 writes the incoming selector, byte enable 1 writes the outgoing selector, and byte enable 2 with a data bit of 1 clears the matching pending bit. With the cause enabled, a peer write whose byte enables cover the selected byte sets bit 16. A write that does not cover that byte does not.
- R7: With the cause enabled, a peer read that clears the selected outgoing byte while it is full sets bit 17.
- R8: `h_irq` rises one edge after the host pending bit is set. After a host write-1-to-clear, it stays high in the following cycle and is low from the edge after that.
- R9: `l_irq` is high from the edge at which a local pending bit is set. It is low in the very cycle that a local write-1-to-clear is presented.
- R10: A cause whose enable bit is 0 never sets its pending bit, even when its event occurs.
- R11: With `l_mode16` high the local port uses data lanes [15:0] and byte enables [1:0], and `l_half` selects the upper (1) or lower (0) half-word of any word. Read data returns the selected half on both halves of `l_rdata`.
- R12: Same-cycle conflicts resolve toward the new event. A write and a read of the same byte leave the flag set, and the read returns the old data. A pending clear that coincides with a new event leaves the pending bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst | input | 1 | Synchronous active-high reset |
| h_req | input | 1 | Host single-beat access strobe |
| h_we | input | 1 | Host write (1) or read (0) |
| h_addr | input | 4 | Host word index |
| h_be | input | 4 | Host byte enables |
| h_wdata | input | 32 | Host write data |
| h_burst | input | 1 | Host initiator wants further data phases |
| h_rdata | output | 32 | Host read data, valid after the access |
| h_disc | output | 1 | Disconnect-with-data request to the bus wrapper |
| h_irq | output | 1 | Registered host interrupt |
| l_req | input | 1 | Local single-beat access strobe |
| l_we | input | 1 | Local write (1) or read (0) |
| l_addr | input | 4 | Local word index |
| l_half | input | 1 | Half-word select in 16-bit mode |
| l_mode16 | input | 1 | Local port runs as a 16-bit bus |
| l_be | input | 4 | Local byte enables |
| l_wdata | input | 32 | Local write data |
| l_rdata | output | 32 | Local read data, valid after the access |
| l_irq | output | 1 | Local interrupt |

## Verification
Two things can land on the same edge. A host write and a local read can hit the same byte of a host-to-local mailbox. A host write-1-to-clear of the incoming-full pending bit can coincide with a local write that raises that same cause again. The bench drives both ports from one task in a single cycle to provoke each case. It then checks that the read returned the pre-write value, that the status word still shows the byte full, and that the control word still shows the pending bit with `h_irq` held high.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int DW     = 32;
  localparam int NB     = DW / 8;
  localparam int NBOX   = 4;
  localparam int NFLAG  = NBOX * NB;
  localparam int HW     = DW / 2;
  localparam int NH     = NB / 2;
  localparam int AW     = 4;
  localparam int BOXW   = $clog2(NBOX);
  localparam int LANEW  = $clog2(NB);
  localparam int GRPW   = AW - BOXW;
  localparam int IDXW   = BOXW + LANEW;

  localparam logic [GRPW-1:0] GRP_OUT = GRPW'(0);
  localparam logic [GRPW-1:0] GRP_IN  = GRPW'(1);
  localparam logic [AW-1:0]   W_CTRL  = AW'(8);
  localparam logic [AW-1:0]   W_STAT  = AW'(9);

  // control word field positions
  localparam int OUT_SEL_LSB = 8;
  localparam int PEND_IN_BIT = 16;
  localparam int PEND_OUT_BIT = 17;
  localparam int BE_IN_SEL  = 0;
  localparam int BE_OUT_SEL = 1;
  localparam int BE_PEND    = 2;

  typedef struct packed {
    logic             en;
    logic [BOXW-1:0]  box;
    logic [LANEW-1:0] lane;
  } irq_sel_t;

  localparam int SELW = $bits(irq_sel_t);
endpackage

// File: rtl/mbox_store.sv
module mbox_store
  import mbox_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NFLAG-1:0]          wmask,
  input  logic [DW-1:0]             wdata,
  input  logic [NFLAG-1:0]          rclr,
  output logic [NBOX-1:0][DW-1:0]   data,
  output logic [NFLAG-1:0]          flags
);
  // byte-wide storage, one writer; flag set dominates a same-cycle clear
  for (genvar k = 0; k < NBOX; k++) begin : g_box
    for (genvar b = 0; b < NB; b++) begin : g_lane
      always_ff @(posedge clk) begin
        if (rst) begin
          data[k][8*b +: 8] <= '0;
        end else if (wmask[k*NB + b]) begin
          data[k][8*b +: 8] <= wdata[8*b +: 8];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= (flags & ~rclr) | wmask;
  end
endmodule

// File: rtl/mbox_port.sv
module mbox_port
  import mbox_pkg::*;
#(
  parameter bit REG_IRQ = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req,
  input  logic                     we,
  input  logic [AW-1:0]            addr,
  input  logic                     half,
  input  logic                     mode16,
  input  logic [NB-1:0]            be,
  input  logic [DW-1:0]            wdata,
  output logic [DW-1:0]            rdata,
  output logic                     irq,
  output logic [1:0]               pend,
  input  logic [NBOX-1:0][DW-1:0]  out_data,
  input  logic [NFLAG-1:0]         out_flags,
  input  logic [NBOX-1:0][DW-1:0]  in_data,
  input  logic [NFLAG-1:0]         in_flags,
  input  logic [NFLAG-1:0]         peer_wmask,
  input  logic [NFLAG-1:0]         peer_rclr,
  output logic [NFLAG-1:0]         own_wmask,
  output logic [NFLAG-1:0]         own_rclr,
  output logic [DW-1:0]            wd_eff
);
  logic [NB-1:0]    be_eff;
  logic [GRPW-1:0]  grp;
  logic [BOXW-1:0]  sel;
  logic             hit_out, hit_in, wr_ctrl;
  logic             clr_in_now, clr_out_now;
  logic             in_evt, out_evt;
  logic             pend_in, pend_out;
  irq_sel_t         in_cfg, out_cfg;
  logic [IDXW-1:0]  idx_in, idx_out;
  logic [DW-1:0]    rd_word, rd_steer, ctrl_word;

  // narrow-bus lane steering
  always_comb begin
    if (mode16) begin
      be_eff = half ? {be[NH-1:0], {NH{1'b0}}} : {{NH{1'b0}}, be[NH-1:0]};
      wd_eff = {wdata[HW-1:0], wdata[HW-1:0]};
    end else begin
      be_eff = be;
      wd_eff = wdata;
    end
  end

  assign grp     = addr[AW-1:BOXW];
  assign sel     = addr[BOXW-1:0];
  assign hit_out = req && (grp == GRP_OUT);
  assign hit_in  = req && (grp == GRP_IN);
  assign wr_ctrl = req && we && (addr == W_CTRL);

  always_comb begin
    own_wmask = '0;
    own_rclr  = '0;
    for (int k = 0; k < NBOX; k++) begin
      if (hit_out && we && (sel == BOXW'(k)))
        own_wmask[k*NB +: NB] = be_eff;
      if (hit_in && !we && (sel == BOXW'(k)))
        own_rclr[k*NB +: NB] = be_eff;
    end
  end

  assign clr_in_now  = wr_ctrl && be_eff[BE_PEND] && wd_eff[PEND_IN_BIT];
  assign clr_out_now = wr_ctrl && be_eff[BE_PEND] && wd_eff[PEND_OUT_BIT];

  assign idx_in  = {in_cfg.box, in_cfg.lane};
  assign idx_out = {out_cfg.box, out_cfg.lane};
  assign in_evt  = peer_wmask[idx_in];
  assign out_evt = peer_rclr[idx_out] && out_flags[idx_out] && !own_wmask[idx_out];

  always_ff @(posedge clk) begin
    if (rst) begin
      in_cfg   <= '0;
      out_cfg  <= '0;
      pend_in  <= 1'b0;
      pend_out <= 1'b0;
    end else begin
      if (wr_ctrl && be_eff[BE_IN_SEL])
        in_cfg <= irq_sel_t'(wd_eff[SELW-1:0]);
      if (wr_ctrl && be_eff[BE_OUT_SEL])
        out_cfg <= irq_sel_t'(wd_eff[OUT_SEL_LSB +: SELW]);
      pend_in  <= (pend_in  && !clr_in_now)  || (in_cfg.en  && in_evt);
      pend_out <= (pend_out && !clr_out_now) || (out_cfg.en && out_evt);
    end
  end

  assign pend = {pend_out, pend_in};

  always_comb begin
    ctrl_word = '0;
    ctrl_word[SELW-1:0]             = in_cfg;
    ctrl_word[OUT_SEL_LSB +: SELW]  = out_cfg;
    ctrl_word[PEND_IN_BIT]          = pend_in;
    ctrl_word[PEND_OUT_BIT]         = pend_out;
  end

  always_comb begin
    rd_word = '0;
    if (grp == GRP_OUT)       rd_word = out_data[sel];
    else if (grp == GRP_IN)   rd_word = in_data[sel];
    else if (addr == W_CTRL)  rd_word = ctrl_word;
    else if (addr == W_STAT)  rd_word = {in_flags, out_flags};
  end

  always_comb begin
    if (mode16) rd_steer = half ? {2{rd_word[DW-1:HW]}} : {2{rd_word[HW-1:0]}};
    else        rd_steer = rd_word;
  end

  always_ff @(posedge clk) begin
    if (rst)              rdata <= '0;
    else if (req && !we)  rdata <= rd_steer;
  end

  if (REG_IRQ) begin : g_irq_reg
    always_ff @(posedge clk) begin
      if (rst) irq <= 1'b0;
      else     irq <= pend_in || pend_out;
    end
  end else begin : g_irq_fast
    always_comb irq = (pend_in && !clr_in_now) || (pend_out && !clr_out_now);
  end
endmodule

// File: rtl/mbox_bank.sv
module mbox_bank
  import mbox_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          h_req,
  input  logic          h_we,
  input  logic [3:0]    h_addr,
  input  logic [3:0]    h_be,
  input  logic [31:0]   h_wdata,
  input  logic          h_burst,
  output logic [31:0]   h_rdata,
  output logic          h_disc,
  output logic          h_irq,
  input  logic          l_req,
  input  logic          l_we,
  input  logic [3:0]    l_addr,
  input  logic          l_half,
  input  logic          l_mode16,
  input  logic [3:0]    l_be,
  input  logic [31:0]   l_wdata,
  output logic [31:0]   l_rdata,
  output logic          l_irq
);
  logic [NBOX-1:0][DW-1:0] h2l_data, l2h_data;
  logic [NFLAG-1:0]        h2l_flags, l2h_flags;
  logic [NFLAG-1:0]        h_wmask, h_rclr, l_wmask, l_rclr;
  logic [DW-1:0]           h_wd, l_wd;
  logic [1:0]              h_pend, l_pend;

  mbox_store u_h2l (
    .clk(clk), .rst(rst), .wmask(h_wmask), .wdata(h_wd), .rclr(l_rclr),
    .data(h2l_data), .flags(h2l_flags)
  );

  mbox_store u_l2h (
    .clk(clk), .rst(rst), .wmask(l_wmask), .wdata(l_wd), .rclr(h_rclr),
    .data(l2h_data), .flags(l2h_flags)
  );

  mbox_port #(.REG_IRQ(1'b1)) u_host (
    .clk(clk), .rst(rst), .req(h_req), .we(h_we), .addr(h_addr),
    .half(1'b0), .mode16(1'b0), .be(h_be), .wdata(h_wdata),
    .rdata(h_rdata), .irq(h_irq), .pend(h_pend),
    .out_data(h2l_data), .out_flags(h2l_flags),
    .in_data(l2h_data), .in_flags(l2h_flags),
    .peer_wmask(l_wmask), .peer_rclr(l_rclr),
    .own_wmask(h_wmask), .own_rclr(h_rclr), .wd_eff(h_wd)
  );

  mbox_port #(.REG_IRQ(1'b0)) u_local (
    .clk(clk), .rst(rst), .req(l_req), .we(l_we), .addr(l_addr),
    .half(l_half), .mode16(l_mode16), .be(l_be), .wdata(l_wdata),
    .rdata(l_rdata), .irq(l_irq), .pend(l_pend),
    .out_data(l2h_data), .out_flags(l2h_flags),
    .in_data(h2l_data), .in_flags(h2l_flags),
    .peer_wmask(h_wmask), .peer_rclr(h_rclr),
    .own_wmask(l_wmask), .own_rclr(l_rclr), .wd_eff(l_wd)
  );

  // single data phase only: ask the wrapper to disconnect after a burst beat
  always_ff @(posedge clk) begin
    if (rst) h_disc <= 1'b0;
    else     h_disc <= h_req && h_burst;
  end
endmodule

// File: rtl/mbox_bank_chk.sv
module mbox_bank_chk (
  input logic        clk,
  input logic        rst,
  input logic        h_req,
  input logic        h_we,
  input logic        h_burst,
  input logic        l_req,
  input logic        l_we,
  input logic        h_disc,
  input logic        h_irq,
  input logic        l_irq,
  input logic [15:0] h2l_flags,
  input logic [15:0] l2h_flags,
  input logic [1:0]  h_pend,
  input logic [1:0]  l_pend
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!h_irq && !l_irq && !h_disc && h2l_flags == '0 && l2h_flags == '0));

  // R5
  disc_after_burst_chk: assert property (@(posedge clk) disable iff (rst)
    (h_req && h_burst) |=> h_disc);

  // R5
  disc_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(h_req && h_burst) |=> !h_disc);

  // R2
  h2l_set_by_write_chk: assert property (@(posedge clk) disable iff (rst)
    !(h_req && h_we) |=> ((h2l_flags & ~$past(h2l_flags)) == '0));

  // R2
  l2h_set_by_write_chk: assert property (@(posedge clk) disable iff (rst)
    !(l_req && l_we) |=> ((l2h_flags & ~$past(l2h_flags)) == '0));

  // R8
  h_irq_from_pend_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(h_irq) |-> $past(|h_pend));

  // R9
  l_irq_from_pend_chk: assert property (@(posedge clk) disable iff (rst)
    l_irq |-> (|l_pend));
endmodule

bind mbox_bank mbox_bank_chk u_chk (.*);

// File: tb/mbox_bank_tb.sv
module mbox_bank_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic h_req = 0, h_we = 0, h_burst = 0;
  logic [3:0] h_addr = '0, h_be = '0;
  logic [31:0] h_wdata = '0;
  logic [31:0] h_rdata;
  logic h_disc, h_irq;
  logic l_req = 0, l_we = 0, l_half = 0, l_mode16 = 0;
  logic [3:0] l_addr = '0, l_be = '0;
  logic [31:0] l_wdata = '0;
  logic [31:0] l_rdata;
  logic l_irq;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbox_bank u_dut (
    .clk(clk), .rst(rst),
    .h_req(h_req), .h_we(h_we), .h_addr(h_addr), .h_be(h_be), .h_wdata(h_wdata),
    .h_burst(h_burst), .h_rdata(h_rdata), .h_disc(h_disc), .h_irq(h_irq),
    .l_req(l_req), .l_we(l_we), .l_addr(l_addr), .l_half(l_half), .l_mode16(l_mode16),
    .l_be(l_be), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_irq(l_irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one access: presented at a falling edge, taken at the next rising edge;
  // returns at the falling edge after it, when read data is valid
  task automatic hacc(input logic we, input logic [3:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    h_req = 1; h_we = we; h_addr = a; h_be = be; h_wdata = d;
    @(negedge clk);
    h_req = 0; h_we = 0;
  endtask

  task automatic lacc(input logic we, input logic [3:0] a, input logic hf, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    l_req = 1; l_we = we; l_addr = a; l_half = hf; l_be = be; l_wdata = d;
    @(negedge clk);
    l_req = 0; l_we = 0;
  endtask

  task automatic t_reset;
    check("R1 h_irq", {31'b0, h_irq}, 0);
    check("R1 l_irq", {31'b0, l_irq}, 0);
    check("R1 h_disc", {31'b0, h_disc}, 0);
    hacc(0, 4'd9, 4'hF, 0);
    check("R1 host status", h_rdata, 0);
  endtask

  task automatic t_basic;
    hacc(1, 4'd1, 4'hF, 32'hA5A5_1234);
    hacc(0, 4'd9, 4'hF, 0);
    check("R2 host status after write", h_rdata, 32'h0000_00F0);
    lacc(0, 4'd9, 0, 4'hF, 0);
    check("R2 local status after write", l_rdata, 32'h00F0_0000);
    lacc(0, 4'd5, 0, 4'hF, 0);
    check("R2 local read data", l_rdata, 32'hA5A5_1234);
    hacc(0, 4'd9, 4'hF, 0);
    check("R2 host status after read", h_rdata, 0);
  endtask

  task automatic t_overwrite_stale;
    hacc(1, 4'd2, 4'h3, 32'h0000_1111);
    hacc(1, 4'd2, 4'h1, 32'h0000_00EE);
    hacc(0, 4'd9, 4'hF, 0);
    check("R3 flags after overwrite", h_rdata, 32'h0000_0300);
    lacc(0, 4'd6, 0, 4'hF, 0);
    check("R3 overwritten data", l_rdata, 32'h0000_11EE);
    lacc(0, 4'd6, 0, 4'hF, 0);
    check("R4 stale read data", l_rdata, 32'h0000_11EE);
    lacc(0, 4'd9, 0, 4'hF, 0);
    check("R4 flags stay clear", l_rdata & 32'h0F00_0000, 0);
  endtask

  task automatic t_burst;
    h_burst = 1;
    hacc(0, 4'd9, 4'hF, 0);
    h_burst = 0;
    check("R5 disc after burst", {31'b0, h_disc}, 1);
    @(negedge clk);
    check("R5 disc drops", {31'b0, h_disc}, 0);
  endtask

  task automatic t_host_full_irq;
    hacc(1, 4'd8, 4'h1, 32'h0000_0016);   // box1 byte2, enabled
    lacc(1, 4'd1, 0, 4'h3, 32'h0000_BEEF);
    @(negedge clk);
    check("R6 unselected byte no irq", {31'b0, h_irq}, 0);
    lacc(1, 4'd1, 0, 4'h4, 32'h0055_0000);
    check("R8 irq not yet", {31'b0, h_irq}, 0);
    @(negedge clk);
    check("R8 irq raised", {31'b0, h_irq}, 1);
    hacc(0, 4'd8, 4'hF, 0);
    check("R6 pending in ctrl", h_rdata, 32'h0001_0016);
    hacc(0, 4'd5, 4'hF, 0);
    check("R6 host read data", h_rdata, 32'h0055_BEEF);
    hacc(1, 4'd8, 4'h4, 32'h0001_0000);
    check("R8 irq held one cycle", {31'b0, h_irq}, 1);
    @(negedge clk);
    check("R8 irq cleared", {31'b0, h_irq}, 0);
  endtask

  task automatic t_host_empty_irq;
    hacc(1, 4'd8, 4'h3, 32'h0000_1316);   // out: box0 byte3, enabled
    hacc(1, 4'd0, 4'h8, 32'h7700_0000);
    lacc(0, 4'd4, 0, 4'h8, 0);
    check("R7 local read data", l_rdata, 32'h7700_0000);
    @(negedge clk);
    check("R7 irq on empty", {31'b0, h_irq}, 1);
    hacc(0, 4'd8, 4'hF, 0);
    check("R7 pending in ctrl", h_rdata, 32'h0002_1316);
    hacc(1, 4'd8, 4'h4, 32'h0002_0000);
    // R10: disable both causes, then provoke the full event
    hacc(1, 4'd8, 4'h3, 32'h0000_0306);
    lacc(1, 4'd1, 0, 4'h4, 32'h00AA_0000);
    @(negedge clk);
    check("R10 disabled no irq", {31'b0, h_irq}, 0);
    hacc(0, 4'd8, 4'hF, 0);
    check("R10 disabled no pending", h_rdata, 32'h0000_0306);
  endtask

  task automatic t_local_irq;
    lacc(1, 4'd8, 0, 4'h1, 32'h0000_001C); // box3 byte0, enabled
    hacc(1, 4'd3, 4'h1, 32'h0000_0042);
    check("R9 l_irq after host write", {31'b0, l_irq}, 1);
    lacc(0, 4'd8, 0, 4'hF, 0);
    check("R9 local pending", l_rdata, 32'h0001_001C);
    @(negedge clk);
    l_req = 1; l_we = 1; l_addr = 4'd8; l_half = 0; l_be = 4'h4; l_wdata = 32'h0001_0000;
    #1;
    check("R9 l_irq drops in clear cycle", {31'b0, l_irq}, 0);
    @(negedge clk);
    l_req = 0; l_we = 0;
    check("R9 l_irq stays low", {31'b0, l_irq}, 0);
  endtask

  task automatic t_narrow;
    l_mode16 = 1;
    hacc(1, 4'd2, 4'hF, 32'hCAFE_F00D);
    lacc(0, 4'd6, 1, 4'h1, 0);
    check("R11 upper half read", l_rdata, 32'hCAFE_CAFE);
    lacc(0, 4'd9, 1, 4'h0, 0);
    check("R11 only byte2 cleared", l_rdata, 32'h1B00_1B00);
    lacc(1, 4'd0, 1, 4'h2, 32'h0000_3C00);
    l_mode16 = 0;
    hacc(0, 4'd4, 4'hF, 0);
    check("R11 narrow write lane", h_rdata, 32'h3C00_0000);
  endtask

  task automatic t_collide;
    hacc(1, 4'd1, 4'h1, 32'h0000_0011);
    @(negedge clk);
    h_req = 1; h_we = 1; h_addr = 4'd1; h_be = 4'h1; h_wdata = 32'h0000_0099;
    l_req = 1; l_we = 0; l_addr = 4'd5; l_half = 0; l_be = 4'h1;
    @(negedge clk);
    h_req = 0; h_we = 0; l_req = 0;
    check("R12 read sees old data", l_rdata, 32'hA5A5_1211);
    lacc(0, 4'd9, 0, 4'hF, 0);
    check("R12 flag survives read", l_rdata & 32'h0010_0000, 32'h0010_0000);
    hacc(1, 4'd8, 4'h1, 32'h0000_0016);
    lacc(1, 4'd1, 0, 4'h4, 32'h0011_0000);
    @(negedge clk);
    h_req = 1; h_we = 1; h_addr = 4'd8; h_be = 4'h4; h_wdata = 32'h0001_0000;
    l_req = 1; l_we = 1; l_addr = 4'd1; l_be = 4'h4; l_wdata = 32'h0022_0000;
    @(negedge clk);
    h_req = 0; h_we = 0; l_req = 0; l_we = 0;
    hacc(0, 4'd8, 4'hF, 0);
    check("R12 pending survives clear", h_rdata, 32'h0001_0316);
    check("R12 irq held", {31'b0, h_irq}, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_basic();
    t_overwrite_stale();
    t_burst();
    t_host_full_irq();
    t_host_empty_irq();
    t_local_irq();
    t_narrow();
    t_collide();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule